// File: doc/BRIEF.md
# Buffered modulo overflow timer

This block is a 16-bit up-counter that runs from a programmable start value to a programmable terminal value and then wraps. Each wrap raises an overflow flag. When the matching enable bit is set, that flag drives an interrupt request. Software reaches the block through a simple write-strobe and address port, and read data comes back combinationally. Through this port it chooses the count clock, sets a power-of-two rate divider, sets the start and terminal values, restarts the counter, and reads or clears the flag.

The start and terminal values are double-buffered. A write always lands in a holding copy. The holding copy moves into the value the counter uses only during a cycle in which the count clock is switched off. Reads of these two registers return the values the counter is using now. A write of any data to the count register restarts the count at the start value in use.

The usual sequence is: stop the clock, program the values, write the count register, then select the system clock. One period then lasts terminal − start + 1 divided ticks. This gives one-shot operation, where software stops the clock in its handler, or free-running periodic operation.

Top module: `modtimer_top`

## Requirements
- R1: After reset, the control, count, terminal and start registers all read 0 and `irq` is low.
- R2: On each divided tick the count goes up by one. A tick that finds the count equal to the terminal value loads the start value instead, and sets the overflow flag on that same edge. A period is terminal − start + 1 ticks.
- R3: Control bits [2:0] hold a divide exponent P, and a tick occurs once every 2^P system clock cycles while the counter runs. The divider restarts from zero whenever the counter is stopped, so the first tick after a start comes 2^P cycles after the start edge.
- R4: Control bits [4:3] select the clock. Only the value 1 makes the counter run. Every other value (0 after reset, 2 or 3) freezes the count at its present value.
- R5: A write of any data to the count register (offset 0x04) loads the start value in use on that edge. This load wins over a tick on the same edge.
- R6: Writes to the terminal register (0x08) and the start register (0x4C) go to holding copies. A holding copy moves into the value in use on every edge at which the clock select is not 1, so it never moves while the counter runs. Reads of 0x08 and 0x4C return the values in use.
- R7: Control bit 7 is the overflow flag. Writing 0 to it in a control write clears it, and writing 1 leaves it unchanged. If a wrap and a clearing write fall on the same edge, the flag ends up set.
- R8: Control bit 6 enables the interrupt, and `irq` is high exactly while both the overflow flag and this bit are 1.
- R9: The control register sits at 0x00 and reads back {flag, enable, 0, clock select, exponent} in bits [7:0]. The count register sits at 0x04. Upper bits of all registers read 0, and every unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench checks the wrap boundary with several start/terminal pairs and dividers. This includes a one-tick period and a range that ends at 0xFFFF, where an off-by-one in the compare or the reload would show up as a wrong count or a missing flag. It places a clearing control write on the same edge as a wrap, which a design that gives the clear priority would lose. It writes new start and terminal values while the counter runs and reads them back before and after stopping, which catches a buffer that moves at the wrong time. It also checks that a nonzero count-register write still loads the start value, that clock-select values 2 and 3 freeze the count, and that writing 1 to the flag does not clear it.

// File: rtl/modtimer_pkg.sv
package modtimer_pkg;

    // register byte offsets
    localparam int unsigned OFS_CTRL  = 32'h00;
    localparam int unsigned OFS_COUNT = 32'h04;
    localparam int unsigned OFS_TERM  = 32'h08;
    localparam int unsigned OFS_START = 32'h4C;

    // control register field positions
    localparam int BIT_TOF  = 7;
    localparam int BIT_TOIE = 6;
    localparam int CS_LSB   = 3;
    localparam int CS_W     = 2;
    localparam int PS_LSB   = 0;

    localparam logic [CS_W-1:0] CS_SYS = 2'd1;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_COUNT,
        SEL_TERM,
        SEL_START,
        SEL_NONE
    } sel_e;

    function automatic sel_e decode_addr(input int unsigned a);
        case (a)
            OFS_CTRL:  return SEL_CTRL;
            OFS_COUNT: return SEL_COUNT;
            OFS_TERM:  return SEL_TERM;
            OFS_START: return SEL_START;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/modtimer_regs.sv
// Control register, double-buffered start/terminal values, overflow flag.
// PS_W may be at most 3 so that the exponent field stays below the clock select.
module modtimer_regs
    import modtimer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  sel_e             sel,
    input  logic [7:0]       ctrl_wd,
    input  logic [CNT_W-1:0] val_wd,
    input  logic             wrap_i,
    output logic             run_o,
    output logic [CS_W-1:0]  cs_o,
    output logic [PS_W-1:0]  ps_o,
    output logic             tof_o,
    output logic             toie_o,
    output logic [CNT_W-1:0] start_o,
    output logic [CNT_W-1:0] term_o,
    output logic             load_o
);

    typedef struct packed {
        logic             tof;
        logic             toie;
        logic [CS_W-1:0]  cs;
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] start_buf;
        logic [CNT_W-1:0] term_buf;
        logic [CNT_W-1:0] start_act;
        logic [CNT_W-1:0] term_act;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;

        // control register write
        if (wr_en && sel == SEL_CTRL) begin
            regs_d.toie = ctrl_wd[BIT_TOIE];
            regs_d.cs   = ctrl_wd[CS_LSB +: CS_W];
            regs_d.ps   = ctrl_wd[PS_LSB +: PS_W];
            if (!ctrl_wd[BIT_TOF]) begin
                regs_d.tof = 1'b0;
            end
        end

        // a wrap on this edge overrides a clearing write
        if (wrap_i) begin
            regs_d.tof = 1'b1;
        end

        // holding copies
        if (wr_en && sel == SEL_START) begin
            regs_d.start_buf = val_wd;
        end
        if (wr_en && sel == SEL_TERM) begin
            regs_d.term_buf = val_wd;
        end

        // transfer only while the count clock is off
        if (regs_q.cs != CS_SYS) begin
            regs_d.start_act = regs_q.start_buf;
            regs_d.term_act  = regs_q.term_buf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign run_o   = (regs_q.cs == CS_SYS);
    assign cs_o    = regs_q.cs;
    assign ps_o    = regs_q.ps;
    assign tof_o   = regs_q.tof;
    assign toie_o  = regs_q.toie;
    assign start_o = regs_q.start_act;
    assign term_o  = regs_q.term_act;
    assign load_o  = wr_en && (sel == SEL_COUNT);

endmodule

// File: rtl/modtimer_presc.sv
// Power-of-two tick divider; cleared whenever the counter is stopped.
module modtimer_presc #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            tick_o
);

    localparam int DIV_W = (1 << PS_W) - 1;
    localparam logic [DIV_W-1:0] ONES = '1;

    typedef struct packed {
        logic [DIV_W-1:0] pcnt;
    } presc_t;

    presc_t presc_d, presc_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        presc_d = presc_q;
        mask    = ~(ONES << ps_i);
        tick_o  = run_i && ((presc_q.pcnt & mask) == mask);
        if (run_i) begin
            presc_d.pcnt = presc_q.pcnt + 1'b1;
        end else begin
            presc_d.pcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_d;
        end
    end

endmodule

// File: rtl/modtimer_cnt.sv
// Modulo counter: start value .. terminal value, wrap pulse on reload.
module modtimer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (load_i) begin
            cnt_d.cnt = start_i;
        end else if (tick_i) begin
            if (cnt_q.cnt == term_i) begin
                cnt_d.cnt = start_i;
                wrap_o    = 1'b1;
            end else begin
                cnt_d.cnt = cnt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q.cnt;

endmodule

// File: rtl/modtimer_top.sv
module modtimer_top
    import modtimer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    sel_e             sel;
    logic             run;
    logic [CS_W-1:0]  cs;
    logic [PS_W-1:0]  ps;
    logic             tof;
    logic             toie;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] term_val;
    logic             cnt_load;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt_val;

    assign sel = decode_addr(32'(addr));

    modtimer_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .ctrl_wd (wdata[7:0]),
        .val_wd  (wdata[CNT_W-1:0]),
        .wrap_i  (wrap),
        .run_o   (run),
        .cs_o    (cs),
        .ps_o    (ps),
        .tof_o   (tof),
        .toie_o  (toie),
        .start_o (start_val),
        .term_o  (term_val),
        .load_o  (cnt_load)
    );

    modtimer_presc #(.PS_W(PS_W)) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .ps_i   (ps),
        .tick_o (tick)
    );

    modtimer_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .load_i  (cnt_load),
        .start_i (start_val),
        .term_i  (term_val),
        .cnt_o   (cnt_val),
        .wrap_o  (wrap)
    );

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[BIT_TOF]            = tof;
                rdata[BIT_TOIE]           = toie;
                rdata[CS_LSB +: CS_W]     = cs;
                rdata[PS_LSB +: PS_W]     = ps;
            end
            SEL_COUNT: rdata[CNT_W-1:0] = cnt_val;
            SEL_TERM:  rdata[CNT_W-1:0] = term_val;
            SEL_START: rdata[CNT_W-1:0] = start_val;
            default:   rdata = '0;
        endcase
    end

    assign irq = tof & toie;

endmodule

// File: rtl/modtimer_chk.sv
module modtimer_chk
    import modtimer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic              tick,
    input logic              run,
    input logic              wrap,
    input logic              tof,
    input logic              toie,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  term_val,
    input logic [CNT_W-1:0]  start_val
);

    logic cnt_wr;
    logic ctrl_wr;
    assign cnt_wr  = wr_en && (32'(addr) == OFS_COUNT);
    assign ctrl_wr = wr_en && (32'(addr) == OFS_CTRL);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !cnt_wr && cnt_val != term_val |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1)); // R2
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !cnt_wr && cnt_val == term_val |=> cnt_val == $past(start_val)); // R2
    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run); // R3
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !cnt_wr |=> $stable(cnt_val)); // R4
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_val == $past(start_val)); // R5
    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(term_val) && $stable(start_val)); // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> tof); // R7
    AST_WRAP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && toie && !ctrl_wr |=> irq); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !tof |-> !irq); // R8

endmodule

bind modtimer_top modtimer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .irq       (irq),
    .tick      (tick),
    .run       (run),
    .wrap      (wrap),
    .tof       (tof),
    .toie      (toie),
    .cnt_val   (cnt_val),
    .term_val  (term_val),
    .start_val (start_val)
);

// File: tb/modtimer_top_tb_top.sv
`timescale 1ns/1ps
module modtimer_top_tb_top;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_COUNT = 8'h04;
    localparam logic [7:0] A_TERM  = 8'h08;
    localparam logic [7:0] A_START = 8'h4C;
    localparam logic [7:0] A_NONE  = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    modtimer_top dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    typedef struct packed {
        logic [15:0] st;
        logic [15:0] tm;
        logic [2:0]  ps;
        logic [15:0] n;
        logic [15:0] ecnt;
        logic        etof;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 16'h0009, 3'd0, 16'd5,  16'h0005, 1'b0},
        '{16'h0000, 16'h0009, 3'd0, 16'd10, 16'h0000, 1'b1},
        '{16'h0064, 16'h0067, 3'd0, 16'd6,  16'h0066, 1'b1},
        '{16'h0000, 16'h0014, 3'd2, 16'd13, 16'h0003, 1'b0},
        '{16'h0005, 16'h0005, 3'd0, 16'd3,  16'h0005, 1'b1},
        '{16'h0010, 16'h001F, 3'd3, 16'd40, 16'h0015, 1'b0},
        '{16'hFFF0, 16'hFFFF, 3'd1, 16'd40, 16'hFFF4, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // caller sits at a negedge; strobe is taken on the next posedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
        rd(A_COUNT, v); check("R1 count", v, 32'h0);
        rd(A_TERM, v);  check("R1 term", v, 32'h0);
        rd(A_START, v); check("R1 start", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 / R3 vector walk
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, 32'h0);
            wr(A_START, {16'h0, VECS[i].st});
            wr(A_TERM, {16'h0, VECS[i].tm});
            wr(A_CTRL, 32'h0);
            wr(A_COUNT, 32'h0);
            wr(A_CTRL, 32'h08 | {29'b0, VECS[i].ps});
            repeat (int'(VECS[i].n)) @(negedge clk);
            rd(A_COUNT, v); check("R2/R3 count", v, {16'h0, VECS[i].ecnt});
            rd(A_CTRL, v);  check("R2 flag", {31'b0, v[7]}, {31'b0, VECS[i].etof});
            check("R9 ctrl readback", {24'b0, v[7:0]} & 32'h7F, 32'h08 | {29'b0, VECS[i].ps});
        end

        // R8 / R7: flag is 1 from last vector
        wr(A_CTRL, 32'hCF);
        check("R8 irq on", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h8F);
        check("R8 irq off with enable 0", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); check("R7 write 1 keeps flag", {31'b0, v[7]}, 32'h1);
        wr(A_CTRL, 32'h00);
        rd(A_CTRL, v); check("R7 write 0 clears", {31'b0, v[7]}, 32'h0);
        wr(A_CTRL, 32'h80);
        rd(A_CTRL, v); check("R7 write 1 does not set", {31'b0, v[7]}, 32'h0);

        // R6 buffering
        wr(A_TERM, 32'h30);
        wr(A_START, 32'h10);
        wr(A_CTRL, 32'h00);
        rd(A_TERM, v);  check("R6 term moved while stopped", v, 32'h30);
        rd(A_START, v); check("R6 start moved while stopped", v, 32'h10);
        wr(A_COUNT, 32'h0);
        wr(A_CTRL, 32'h0F);
        wr(A_TERM, 32'h99);
        wr(A_START, 32'h55);
        repeat (3) @(negedge clk);
        rd(A_TERM, v);  check("R6 term frozen while running", v, 32'h30);
        rd(A_START, v); check("R6 start frozen while running", v, 32'h10);
        // R5 any data loads start value in use
        wr(A_COUNT, 32'hABCD);
        rd(A_COUNT, v); check("R5 count load", v, 32'h10);
        wr(A_CTRL, 32'h00);
        wr(A_CTRL, 32'h00);
        rd(A_TERM, v);  check("R6 term after stop", v, 32'h99);
        rd(A_START, v); check("R6 start after stop", v, 32'h55);

        // R4 clock select 2 freezes
        wr(A_COUNT, 32'h0);
        wr(A_CTRL, 32'h08);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h10);
        rd(A_COUNT, v); check("R4 count at stop", v, 32'h59);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); check("R4 held with select 2", v, 32'h59);
        wr(A_CTRL, 32'h18);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); check("R4 held with select 3", v, 32'h59);

        // R7 set wins over clear on the same edge
        wr(A_START, 32'h0);
        wr(A_TERM, 32'h3);
        wr(A_CTRL, 32'h00);
        wr(A_COUNT, 32'h0);
        wr(A_CTRL, 32'h08);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h08);
        rd(A_CTRL, v);  check("R7 set beats clear", {31'b0, v[7]}, 32'h1);
        rd(A_COUNT, v); check("R2 reload at wrap", v, 32'h0);
        wr(A_CTRL, 32'h08);
        rd(A_CTRL, v);  check("R7 clear after wrap", {31'b0, v[7]}, 32'h0);
        rd(A_COUNT, v); check("R2 count after wrap", v, 32'h1);

        // R9 unmapped
        rd(A_NONE, v); check("R9 unmapped reads 0", v, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule